// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Bus Driver Control

This block is the transmit side of a serial port on a shared two-wire bus where every node's driver and receiver sit on the same pair. It frames bytes as one start bit, eight data bits and one stop bit. It also produces the driver-enable signal for the line transceiver. That signal is raised before the first start bit and held across consecutive bytes. It is dropped as early as safely possible once the last character has left the wire, so another node can answer quickly.

Software writes bytes into a four-entry FIFO. Bit timing comes from a single-cycle `baud_tick` strobe, one per bit time; at 115200 baud a whole character lasts about 87 µs.

Two end-of-packet policies are offered:
- **Guard mode** keeps the driver on for a programmable number of idle bit times after the final stop bit.
- **Trailer mode** drives only the start bit of an appended all-ones byte and then lets go. Because the bus idles at logic 1, the rest of that byte reads as idle.

One interrupt output can be routed from one of three transmit conditions.

The controller is a state machine with these states:
- `S_IDLE`: driver off.
- `S_LEAD`: driver on, waiting for a tick.
- `S_START`: start bit.
- `S_DATA`: data bits.
- `S_STOP`: stop bit.
- `S_GUARD`: idle bits with the driver still on.
- `S_TRAIL`: trailer start bit.

Its transitions are:
- IDLE→LEAD when the FIFO holds data.
- LEAD→START on a tick, popping a byte.
- START→DATA on a tick.
- DATA→STOP on the tick after the eighth bit.
- STOP→START on a tick if the FIFO holds data (pop).
- STOP→TRAIL on a tick in trailer mode.
- STOP→IDLE on a tick when the guard is zero.
- STOP→GUARD on a tick otherwise.
- GUARD→START on a tick if data arrived (pop).
- GUARD→IDLE on the tick that ends the last guard bit.
- TRAIL→IDLE on a tick.

Top module: `rs485_tx_de`

## Requirements
- R1: Each character is sent as a start bit of 0, then data bits least significant first, then one stop bit of 1, each lasting one tick period. `tx` is 1 whenever no frame bit is being driven.
- R2: `hold_ready` is 1 exactly when the FIFO is not full. `shift_empty` is 1 only when no character is being shifted and the stop bit of the last one has ended, so `hold_ready` can be 1 while `shift_empty` is 0. `tx` is 1 whenever `shift_empty` is 1.
- R3: `de` rises the clock after data is present while idle. The first start bit begins on the first tick after `de` rises. Queued bytes follow one another with no idle bit between frames and `de` held high.
- R4: With `cfg_trailer`=0, after the final stop bit `de` stays high, with `tx`=1, for `cfg_guard` bit times (0..15) and then falls. A guard of 0 releases `de` at the end of the stop bit.
- R5: A byte written while the guard is running (including its last bit time) keeps `de` high. Its start bit begins on the next tick.
- R6: With `cfg_trailer`=1, after the final stop bit a trailer start bit (0) is driven for one bit time. Then `de` falls and `tx` returns to 1. `cfg_guard` has no effect in this mode.
- R7: The FIFO holds 4 bytes. A write while full that is not matched by a pop in the same cycle is discarded and sets `overflow`, which stays 1 until reset.
- R8: `cfg_irq_sel` picks the interrupt source:
  - 0: FIFO not full.
  - 1: `shift_empty` and FIFO empty.
  - 2: a one-clock pulse in the cycle after each byte moves from the FIFO into the shifter.
  - 3: `irq` held at 0.
- R9: While and after reset: `tx`=1, `de`=0, `shift_empty`=1, `hold_ready`=1, `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a byte into the FIFO |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-clock strobe per bit time |
| cfg_guard | input | 4 | Guard length in bit times |
| cfg_trailer | input | 1 | 1 selects trailer mode, 0 selects guard mode |
| cfg_irq_sel | input | 2 | Interrupt source select |
| tx | output | 1 | Serial data to the transceiver |
| de | output | 1 | Transceiver driver enable |
| hold_ready | output | 1 | FIFO can accept a byte |
| shift_empty | output | 1 | Last character fully sent |
| overflow | output | 1 | Sticky write-while-full flag |
| irq | output | 1 | Selected transmit interrupt |

## Verification
The release of the driver at the last guard tick and the arrival of a new byte can fall on the same cycle. A write pushed just before that tick must win and turn the tick into a start bit rather than a release. The bench provokes this by injecting a byte during the final guard bit, as well as earlier in the guard. It judges the outcome from the per-bit samples of `tx` and `de`: the second frame must begin immediately and the full guard must follow it. A FIFO pop and a further write can also coincide while the FIFO is full. The bench provokes this with a burst of seven back-to-back writes and checks that exactly the unmatched writes raise `overflow`.

// File: rtl/rs485_tx_pkg.sv
`timescale 1ns/1ps
package rs485_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_START, S_DATA, S_STOP, S_GUARD, S_TRAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        IRQ_SPACE = 2'd0,
        IRQ_DONE  = 2'd1,
        IRQ_LOAD  = 2'd2,
        IRQ_OFF   = 2'd3
    } irq_sel_e;
endpackage

// File: rtl/tx_fifo.sv
`timescale 1ns/1ps
module tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && !do_push) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> overflow);
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tx_fsm.sv
`timescale 1ns/1ps
module tx_fsm
    import rs485_tx_pkg::*;
#(
    parameter int DW      = 8,
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               fifo_empty,
    input  logic [DW-1:0]      fifo_rdata,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               cfg_trailer,
    output logic               fifo_pop,
    output logic               tx,
    output logic               de,
    output logic               shift_empty,
    output logic               load_evt
);
    localparam int BW = $clog2(DW);

    tx_state_e          st, nxt;
    logic [DW-1:0]      shreg;
    logic [BW-1:0]      bitcnt;
    logic [GUARD_W-1:0] gcnt;

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (!fifo_empty) nxt = S_LEAD;
            S_LEAD:  if (baud_tick) nxt = S_START;
            S_START: if (baud_tick) nxt = S_DATA;
            S_DATA:  if (baud_tick && bitcnt == BW'(DW - 1)) nxt = S_STOP;
            S_STOP:  if (baud_tick) begin
                         if (!fifo_empty)          nxt = S_START;
                         else if (cfg_trailer)     nxt = S_TRAIL;
                         else if (cfg_guard == '0) nxt = S_IDLE;
                         else                      nxt = S_GUARD;
                     end
            S_GUARD: if (baud_tick) begin
                         if (!fifo_empty)                     nxt = S_START;
                         else if (gcnt == GUARD_W'(1))        nxt = S_IDLE;
                     end
            S_TRAIL: if (baud_tick) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign fifo_pop = baud_tick && !fifo_empty &&
                      (st == S_LEAD || st == S_STOP || st == S_GUARD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // shifter, bit and guard counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '1;
            bitcnt   <= '0;
            gcnt     <= '0;
            load_evt <= 1'b0;
        end else begin
            load_evt <= fifo_pop;
            if (fifo_pop) begin
                shreg  <= fifo_rdata;
                bitcnt <= '0;
            end else if (st == S_DATA && baud_tick) begin
                shreg  <= {1'b1, shreg[DW-1:1]};
                bitcnt <= bitcnt + 1'b1;
            end
            if (st == S_STOP && baud_tick)       gcnt <= cfg_guard;
            else if (st == S_GUARD && baud_tick) gcnt <= gcnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx          = 1'b1;
        de          = 1'b1;
        shift_empty = 1'b0;
        unique case (st)
            S_IDLE:  begin de = 1'b0; shift_empty = 1'b1; end
            S_LEAD:  shift_empty = 1'b1;
            S_START: tx = 1'b0;
            S_DATA:  tx = shreg[0];
            S_STOP:  tx = 1'b1;
            S_GUARD: shift_empty = 1'b1;
            S_TRAIL: tx = 1'b0;
            default: begin de = 1'b0; shift_empty = 1'b1; end
        endcase
    end

    assert_low_needs_driver_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx |-> de);
    assert_start_after_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx) |-> $past(de));
    assert_empty_is_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx);
    assert_release_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> ($past(baud_tick) &&
                      ($past(st) == S_STOP || $past(st) == S_GUARD || $past(st) == S_TRAIL)));
    assert_guard_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_GUARD && !fifo_empty && baud_tick) |=> (st == S_START && de));
    assert_trailer_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TRAIL && baud_tick) |=> (!de && tx));
endmodule

// File: rtl/tx_irq_mux.sv
`timescale 1ns/1ps
module tx_irq_mux
    import rs485_tx_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       space,
    input  logic       done,
    input  logic       load_evt,
    output logic       irq
);
    always_comb begin
        unique case (irq_sel_e'(sel))
            IRQ_SPACE: irq = space;
            IRQ_DONE:  irq = done;
            IRQ_LOAD:  irq = load_evt;
            IRQ_OFF:   irq = 1'b0;
            default:   irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/rs485_tx_de.sv
`timescale 1ns/1ps
module rs485_tx_de #(
    parameter int DW      = 8,
    parameter int DEPTH   = 4,
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic               baud_tick,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               cfg_trailer,
    input  logic [1:0]         cfg_irq_sel,
    output logic               tx,
    output logic               de,
    output logic               hold_ready,
    output logic               shift_empty,
    output logic               overflow,
    output logic               irq
);
    logic          f_empty, f_full, f_pop, load_evt;
    logic [DW-1:0] f_rdata;

    tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data), .pop(f_pop),
        .rdata(f_rdata), .empty(f_empty), .full(f_full), .overflow(overflow)
    );

    tx_fsm #(.DW(DW), .GUARD_W(GUARD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_empty(f_empty),
        .fifo_rdata(f_rdata), .cfg_guard(cfg_guard), .cfg_trailer(cfg_trailer),
        .fifo_pop(f_pop), .tx(tx), .de(de), .shift_empty(shift_empty),
        .load_evt(load_evt)
    );

    assign hold_ready = !f_full;

    tx_irq_mux u_irq (
        .sel(cfg_irq_sel), .space(!f_full), .done(shift_empty && f_empty),
        .load_evt(load_evt), .irq(irq)
    );

    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_sel == 2'd3) |-> !irq);
endmodule

// File: tb/tb_rs485_tx_de.sv
`timescale 1ns/1ps
module tb_rs485_tx_de;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick;
    logic [3:0] cfg_guard = '0;
    logic       cfg_trailer = 1'b0;
    logic [1:0] cfg_irq_sel = '0;
    logic tx, de, hold_ready, shift_empty, overflow, irq;

    always #2 clk = ~clk;

    logic [1:0] div = '0;
    always @(posedge clk) div <= div + 1'b1;
    assign baud_tick = (div == 2'd3);

    rs485_tx_de dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .cfg_guard(cfg_guard), .cfg_trailer(cfg_trailer),
        .cfg_irq_sel(cfg_irq_sel), .tx(tx), .de(de), .hold_ready(hold_ready),
        .shift_empty(shift_empty), .overflow(overflow), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // lead measurement: ticks seen with de high before first start bit
    int  tk = 0, lead_meas = -1;
    bit  armed = 1'b0;
    int  irq_hi = 0;
    always @(posedge clk) begin
        if (!de) begin armed = 1'b1; tk = 0; end
        else if (baud_tick) tk = tk + 1;
    end
    always @(negedge clk) begin
        if (armed && de && !tx) begin lead_meas = tk; armed = 1'b0; end
        if (irq) irq_hi++;
    end

    logic [7:0] pk [4];
    logic etx [256];
    logic ede [256];
    logic ese [256];
    int   ne;

    task automatic add(input logic t, input logic d, input logic s);
        etx[ne] = t; ede[ne] = d; ese[ne] = s; ne++;
    endtask

    task automatic add_frame(input logic [7:0] b);
        add(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) add(b[i], 1'b1, 1'b0);
        add(1'b1, 1'b1, 1'b0);
    endtask

    task automatic wait_sample();
        do @(negedge clk); while (div != 2'd0);
    endtask

    task automatic run_case(input int n, input int g, input bit trl, input int sel,
                            input int inj, input logic [7:0] bi, input string tag);
        int mtx = 0, mde = 0, mse = 0, mirq = 0;
        ne = 0;
        for (int i = 0; i < n; i++) add_frame(pk[i]);
        if (inj >= 0) begin
            for (int k = 10 * n; k <= inj; k++) add(1'b1, 1'b1, 1'b1);
            add_frame(bi);
        end
        if (trl) begin
            add(1'b0, 1'b1, 1'b0);
            add(1'b1, 1'b0, 1'b1);
        end else begin
            for (int k = 0; k < g; k++) add(1'b1, 1'b1, 1'b1);
            add(1'b1, 1'b0, 1'b1);
        end
        add(1'b1, 1'b0, 1'b1);

        cfg_guard = 4'(g); cfg_trailer = trl; cfg_irq_sel = 2'(sel);
        wait_sample();
        irq_hi = 0; lead_meas = -1;
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = pk[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        while (div != 2'd0) @(negedge clk);
        for (int k = 0; k < ne; k++) begin
            if (k > 0) wait_sample();
            if (tx !== etx[k]) mtx++;
            if (de !== ede[k]) mde++;
            if (shift_empty !== ese[k]) mse++;
            if (sel == 0 && irq !== 1'b1) mirq++;
            if (sel == 1 && irq !== ese[k]) mirq++;
            if (sel == 3 && irq !== 1'b0) mirq++;
            if (k == inj) begin
                wr_en = 1'b1; wr_data = bi;
                @(negedge clk);
                wr_en = 1'b0;
            end
        end
        chk({"R1 tx bits ", tag}, mtx, 0);
        chk({"de window ", tag}, mde, 0);
        chk({"R2 shift_empty ", tag}, mse, 0);
        chk({"R3 lead ticks ", tag}, lead_meas, 1);
        if (sel == 2) chk({"R8 load pulses ", tag}, irq_hi, n + (inj >= 0 ? 1 : 0));
        else          chk({"R8 irq level ", tag}, mirq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        chk("R9 tx", int'(tx), 1);
        chk("R9 de", int'(de), 0);
        chk("R9 shift_empty", int'(shift_empty), 1);
        chk("R9 hold_ready", int'(hold_ready), 1);
        chk("R9 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R6 R3: sweep of count, guard and mode
        for (int tr = 0; tr < 2; tr++)
            for (int n = 1; n <= 4; n++)
                for (int g = 0; g < 16; g++) begin
                    for (int i = 0; i < 4; i++) pk[i] = 8'((g * 29 + n * 71 + i * 53 + tr * 7) ^ 8'h5A);
                    run_case(n, g, tr[0], g % 4, -1, 8'h00, tr != 0 ? "R6" : "R4");
                end

        // R1 exhaustive byte values, single frame
        for (int v = 0; v < 256; v++) begin
            pk[0] = 8'(v);
            run_case(1, 1, 1'b0, 1, -1, 8'h00, "R1 byte");
        end

        // R5 writes during guard, early and in the last guard bit
        pk[0] = 8'hC3;
        run_case(1, 8, 1'b0, 2, 12, 8'h3C, "R5 mid guard");
        pk[0] = 8'h81; pk[1] = 8'h7E;
        run_case(2, 3, 1'b0, 1, 22, 8'hA5, "R5 last guard bit");
        pk[0] = 8'h10;
        run_case(1, 1, 1'b0, 0, 10, 8'hEF, "R5 guard of one");

        // R7 R2 R8 overflow burst of seven writes
        cfg_guard = 4'd0; cfg_trailer = 1'b0; cfg_irq_sel = 2'd0;
        wait_sample();
        for (int i = 0; i < 7; i++) begin
            wr_en = 1'b1; wr_data = 8'(i + 1);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R7 overflow set", int'(overflow), 1);
        chk("R2 hold_ready full", int'(hold_ready), 0);
        chk("R8 space irq full", int'(irq), 0);
        wait (de == 1'b0);
        @(negedge clk);
        chk("R7 overflow sticky", int'(overflow), 1);
        chk("R2 hold_ready drained", int'(hold_ready), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 overflow cleared", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule